// File: doc/BRIEF.md
# ECC Error Interrupt Aggregator

This block gathers the error strobes that the ECC logic of one protected RAM raises, in two classes: corrected single-bit errors (SEC) and detected but uncorrectable double-bit errors (DED). Each class keeps a pending flag, an interrupt enable and an arming flag. Each class drives its own pulse interrupt. A pulse fires once when the class is pending, enabled and armed. An end-of-interrupt (EOI) write from the handler re-arms the class, so that an event still outstanding, or a later one, produces a fresh pulse.

Software reaches the block through a flat register port. Writes take effect on the clock edge, and reads are combinational from the address. The two classes use the same register layout, and the DED group sits 0x100 above the SEC group. A read-only revision word and a read-only RAM-count word complete the map. Hardware can also drop a pending flag through a dedicated clear strobe.

Top module: `ecc_irq_aggr`

## Requirements
- R1: After synchronous active-low reset, both pending flags and both enables are 0, both classes are armed, and both interrupt outputs are low.
- R2: Offset 0x000 always reads 0x66A0EA00. This is the scheme field 1 in bits 31:30, unit 2 in bits 29:28, module 0x6A0 in bits 27:16, RTL version 0x1D in bits 15:11, major 2 in bits 10:8, and 0 in bits 7:0. Writes to it have no effect.
- R3: Offset 0x00C reads the parameter NUM_RAMS in bits 10:0 and 0 in bits 31:11. Writes to it have no effect.
- R4: A write with bit 0 = 1 to the enable-set offset (SEC 0x080, DED 0x180) sets that class's enable. A write with bit 0 = 1 to the enable-clear offset (SEC 0x0C0, DED 0x1C0) clears it. Both offsets read the current enable in bit 0.
- R5: A write with bit 0 = 0 to an enable-set or enable-clear offset leaves the enable unchanged.
- R6: A high sec_evt or ded_evt at a clock edge sets the matching pending flag, which reads in bit 0 of the pending offset (SEC 0x040, DED 0x140).
- R7: A write to the pending offset loads bit 0 into the flag (1 sets it, 0 clears it). A high clear strobe (sec_clr or ded_clr) clears the flag. A hardware event at the same edge wins over either kind of clear.
- R8: The interrupt output of a class is high for exactly one cycle, starting the cycle after the edge where the class first becomes pending, enabled and armed. The class is then disarmed.
- R9: A disarmed class produces no pulse, whatever its pending and enable state, until a write with bit 0 = 1 reaches its EOI offset (SEC 0x03C, DED 0x13C). An EOI write with bit 0 = 0 is ignored, and the EOI offset reads 0.
- R10: An EOI write with bit 0 = 1 while the class is still pending and enabled produces a new pulse in the cycle after the write.
- R11: Unmapped offsets and all bits other than the defined fields read 0. Writes to unmapped offsets change no state.
- R12: The two classes are independent: strobes and writes aimed at one class never change the other class's flags or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr_en | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| sec_evt | input | 1 | Single-error-corrected event strobe |
| ded_evt | input | 1 | Double-error-detected event strobe |
| sec_clr | input | 1 | Hardware clear of the SEC pending flag |
| ded_clr | input | 1 | Hardware clear of the DED pending flag |
| sec_irq | output | 1 | SEC pulse interrupt |
| ded_irq | output | 1 | DED pulse interrupt |

## Verification
The bench builds the block with NUM_RAMS set to 3 rather than the default 1. A RAM-count field that was tied to a constant, or cut to the wrong width, then shows up as a wrong value. ADDR_W stays at 10, which is wide enough that every DED offset and several unmapped offsets, including ones that alias a SEC offset in the low byte, can be reached. This exposes a decoder that ignores the class-select bit. Random strobes, clears and writes then mix disarmed, re-armed, and simultaneous set-and-clear situations on both classes at once.

// File: rtl/ecc_irq_pkg.sv
// Package: constants and types shared by the ECC interrupt aggregator.
// Assumes byte offsets within a 32-bit register space; the class groups
// repeat at a fixed stride.
package ecc_irq_pkg;

    localparam int unsigned NUM_CLASSES  = 2;
    localparam int unsigned CLASS_STRIDE = 32'h100;

    // Class indices: order fixes the DED group at base + stride.
    localparam int unsigned CLS_SEC = 0;
    localparam int unsigned CLS_DED = 1;

    // Global offsets
    localparam int unsigned OFS_REV  = 32'h000;
    localparam int unsigned OFS_RAMS = 32'h00C;

    // Per-class offsets, relative to class base
    localparam int unsigned OFS_EOI   = 32'h03C;
    localparam int unsigned OFS_PEND  = 32'h040;
    localparam int unsigned OFS_ENSET = 32'h080;
    localparam int unsigned OFS_ENCLR = 32'h0C0;

    // Revision fields
    localparam logic [1:0]  REV_SCHEME = 2'd1;
    localparam logic [1:0]  REV_UNIT   = 2'd2;
    localparam logic [11:0] REV_MODULE = 12'h6A0;
    localparam logic [4:0]  REV_RTL    = 5'h1D;
    localparam logic [2:0]  REV_MAJOR  = 3'd2;
    localparam logic [1:0]  REV_CUSTOM = 2'd0;
    localparam logic [5:0]  REV_MINOR  = 6'd0;

    localparam logic [31:0] REV_WORD = {REV_SCHEME, REV_UNIT, REV_MODULE,
                                        REV_RTL, REV_MAJOR, REV_CUSTOM, REV_MINOR};

    localparam int unsigned RAM_CNT_W = 11;

    // Decoded per-class write commands (bit 0 of write data already applied
    // where the command is a write-one action).
    typedef struct packed {
        logic eoi;       // re-arm request
        logic pend_wr;   // pending flag load
        logic pend_val;  // value to load
        logic en_set;    // enable set request
        logic en_clr;    // enable clear request
    } cls_cmd_t;

endpackage

// File: rtl/ecc_irq_regdec.sv
// Register decoder: turns the flat register port into per-class commands
// and builds the read word from the per-class state.
// Assumes a single access per cycle and word-aligned byte offsets.
module ecc_irq_regdec
    import ecc_irq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned NUM_RAMS = 1,
    parameter int unsigned NCLS     = NUM_CLASSES
) (
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic                      reg_wr_en,
    input  logic [31:0]               reg_wdata,
    input  logic [NCLS-1:0]           pend_vec,
    input  logic [NCLS-1:0]           en_vec,
    output cls_cmd_t [NCLS-1:0]       cmd_vec,
    output logic [31:0]               reg_rdata
);

    localparam logic [ADDR_W-1:0]    A_REV  = ADDR_W'(OFS_REV);
    localparam logic [ADDR_W-1:0]    A_RAMS = ADDR_W'(OFS_RAMS);
    localparam logic [RAM_CNT_W-1:0] RAMS_V = RAM_CNT_W'(NUM_RAMS);

    logic [NCLS-1:0] hit_eoi, hit_pend, hit_enset, hit_enclr;
    logic [NCLS-1:0] rd_bit;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        localparam logic [ADDR_W-1:0] A_EOI   = ADDR_W'(OFS_EOI   + c * CLASS_STRIDE);
        localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFS_PEND  + c * CLASS_STRIDE);
        localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(OFS_ENSET + c * CLASS_STRIDE);
        localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(OFS_ENCLR + c * CLASS_STRIDE);

        // Offset match for this class's group
        always_comb begin
            hit_eoi[c]   = (reg_addr == A_EOI);
            hit_pend[c]  = (reg_addr == A_PEND);
            hit_enset[c] = (reg_addr == A_ENSET);
            hit_enclr[c] = (reg_addr == A_ENCLR);
        end

        // Write command for this class
        always_comb begin
            cmd_vec[c].eoi      = reg_wr_en && hit_eoi[c]   && reg_wdata[0];
            cmd_vec[c].pend_wr  = reg_wr_en && hit_pend[c];
            cmd_vec[c].pend_val = reg_wdata[0];
            cmd_vec[c].en_set   = reg_wr_en && hit_enset[c] && reg_wdata[0];
            cmd_vec[c].en_clr   = reg_wr_en && hit_enclr[c] && reg_wdata[0];
        end

        // Read contribution of this class (EOI reads as 0)
        always_comb begin
            rd_bit[c] = (hit_pend[c] & pend_vec[c]) |
                        ((hit_enset[c] | hit_enclr[c]) & en_vec[c]);
        end
    end

    // Read mux: global words, then OR of class bits in bit 0
    always_comb begin
        if (reg_addr == A_REV) begin
            reg_rdata = REV_WORD;
        end else if (reg_addr == A_RAMS) begin
            reg_rdata = {{(32 - RAM_CNT_W){1'b0}}, RAMS_V};
        end else begin
            reg_rdata = {31'd0, |rd_bit};
        end
    end

endmodule

// File: rtl/ecc_irq_class.sv
// One interrupt class: pending flag, enable flag, arming flag and the pulse.
// Assumes the decoder gives at most one register command per cycle.
// The pulse is a combinational function of registered state.
module ecc_irq_class
    import ecc_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cls_cmd_t cmd,
    input  logic     hw_evt,
    input  logic     hw_clr,
    output logic     pend,
    output logic     en,
    output logic     irq
);

    logic armed;

    // Pulse when a pending, enabled class is armed
    always_comb irq = pend & en & armed;

    // Pending flag: hardware event wins over any clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (hw_evt) begin
            pend <= 1'b1;
        end else if (cmd.pend_wr) begin
            pend <= cmd.pend_val;
        end else if (hw_clr) begin
            pend <= 1'b0;
        end
    end

    // Enable flag: separate set and clear offsets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else if (cmd.en_set) begin
            en <= 1'b1;
        end else if (cmd.en_clr) begin
            en <= 1'b0;
        end
    end

    // Arming flag: EOI re-arms, a pulse disarms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
        end else if (cmd.eoi) begin
            armed <= 1'b1;
        end else if (irq) begin
            armed <= 1'b0;
        end
    end

endmodule

// File: rtl/ecc_irq_aggr.sv
// ECC error interrupt aggregator top: two classes (SEC, DED) behind one
// register port. Assumes the event and clear strobes are synchronous to clk.
module ecc_irq_aggr
    import ecc_irq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned NUM_RAMS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              sec_evt,
    input  logic              ded_evt,
    input  logic              sec_clr,
    input  logic              ded_clr,
    output logic              sec_irq,
    output logic              ded_irq
);

    localparam int unsigned NCLS = NUM_CLASSES;

    logic [NCLS-1:0]     evt_vec, clr_vec, pend_vec, en_vec, irq_vec;
    cls_cmd_t [NCLS-1:0] cmd_vec;

    // Gather strobes into class-indexed vectors
    always_comb begin
        evt_vec[CLS_SEC] = sec_evt;
        evt_vec[CLS_DED] = ded_evt;
        clr_vec[CLS_SEC] = sec_clr;
        clr_vec[CLS_DED] = ded_clr;
    end

    ecc_irq_regdec #(
        .ADDR_W   (ADDR_W),
        .NUM_RAMS (NUM_RAMS),
        .NCLS     (NCLS)
    ) u_dec (
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .pend_vec  (pend_vec),
        .en_vec    (en_vec),
        .cmd_vec   (cmd_vec),
        .reg_rdata (reg_rdata)
    );

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        ecc_irq_class u_cls (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd    (cmd_vec[c]),
            .hw_evt (evt_vec[c]),
            .hw_clr (clr_vec[c]),
            .pend   (pend_vec[c]),
            .en     (en_vec[c]),
            .irq    (irq_vec[c])
        );
    end

    // Drive the interrupt outputs from the class vector
    always_comb begin
        sec_irq = irq_vec[CLS_SEC];
        ded_irq = irq_vec[CLS_DED];
    end

endmodule

// File: rtl/ecc_irq_aggr_chk.sv
// Checker for the ECC interrupt aggregator, attached by bind below.
// Assumes the same offset map as the design package.
module ecc_irq_aggr_chk
    import ecc_irq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned NUM_RAMS = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic                   reg_wr_en,
    input logic [31:0]            reg_wdata,
    input logic [31:0]            reg_rdata,
    input logic [NUM_CLASSES-1:0] evt_vec,
    input logic [NUM_CLASSES-1:0] clr_vec,
    input logic [NUM_CLASSES-1:0] pend_vec,
    input logic [NUM_CLASSES-1:0] en_vec,
    input logic [NUM_CLASSES-1:0] irq_vec
);

    // R1: outputs quiet in the first cycle after reset release
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_vec == '0));

    // R2: revision word constant
    p_rev_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_REV)) |-> (reg_rdata == 32'h66A0EA00));

    // R3: RAM count word
    p_ram_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_RAMS)) |-> (reg_rdata == 32'(NUM_RAMS)));

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
        logic eoi_w, pend_w;
        always_comb begin
            eoi_w  = reg_wr_en && reg_wdata[0] &&
                     (reg_addr == ADDR_W'(OFS_EOI + c * CLASS_STRIDE));
            pend_w = reg_wr_en && (reg_addr == ADDR_W'(OFS_PEND + c * CLASS_STRIDE));
        end

        // R6: event sets pending
        p_evt_sets_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
            evt_vec[c] |=> pend_vec[c]);

        // R7: clear strobe drops pending when no event and no status write
        p_clr_drops_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[c] && !evt_vec[c] && !pend_w) |=> !pend_vec[c]);

        // R8: a pulse lasts one cycle unless re-armed in that cycle
        p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_vec[c] && !eoi_w) |=> !irq_vec[c]);

        // R10: EOI while pending and enabled gives a pulse next cycle
        p_eoi_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_w && pend_vec[c] && en_vec[c] && !clr_vec[c]) |=> irq_vec[c]);
    end

endmodule

bind ecc_irq_aggr ecc_irq_aggr_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_RAMS (NUM_RAMS)
) chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_vec   (evt_vec),
    .clr_vec   (clr_vec),
    .pend_vec  (pend_vec),
    .en_vec    (en_vec),
    .irq_vec   (irq_vec)
);

// File: tb/ecc_irq_aggr_test.sv
// Bench for the ECC interrupt aggregator: directed corner cases followed by
// seeded random traffic, checked against a bench model of the requirements.
module ecc_irq_aggr_test;

    localparam int unsigned AW    = 10;
    localparam int unsigned NRAMS = 3;
    localparam int unsigned MAXC  = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr_en = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          sec_evt = 1'b0, ded_evt = 1'b0, sec_clr = 1'b0, ded_clr = 1'b0;
    logic          sec_irq, ded_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Bench model state, per class
    bit m_pend [2];
    bit m_en   [2];
    bit m_arm  [2];

    always #10ns clk = ~clk;

    ecc_irq_aggr #(.ADDR_W(AW), .NUM_RAMS(NRAMS)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_evt(sec_evt),
        .ded_evt(ded_evt), .sec_clr(sec_clr), .ded_clr(ded_clr),
        .sec_irq(sec_irq), .ded_irq(ded_irq)
    );

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
        if (a == 10'h000) return 32'h66A0EA00;     // R2
        if (a == 10'h00C) return 32'(NRAMS);       // R3
        for (int c = 0; c < 2; c++) begin
            logic [AW-1:0] b = AW'(c * 32'h100);
            if (a == b + 10'h040) return {31'd0, m_pend[c]};
            if (a == b + 10'h080 || a == b + 10'h0C0) return {31'd0, m_en[c]};
        end
        return 32'd0;                              // R11, EOI included
    endfunction

    function automatic bit exp_irq(input int c);
        return m_pend[c] & m_en[c] & m_arm[c];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // One clock cycle of stimulus, checks and model update
    task automatic cyc(input string req, input logic [1:0] evt, input logic [1:0] clr,
                       input logic we, input logic [AW-1:0] a, input logic [31:0] d);
        bit np [2];
        bit ne [2];
        bit na [2];
        @(negedge clk);
        sec_evt = evt[0]; ded_evt = evt[1];
        sec_clr = clr[0]; ded_clr = clr[1];
        reg_wr_en = we; reg_addr = a; reg_wdata = d;
        #1;
        check({req, " sec_irq"}, {31'd0, sec_irq}, {31'd0, exp_irq(0)});
        check({req, " ded_irq"}, {31'd0, ded_irq}, {31'd0, exp_irq(1)});
        if (!we) check({req, " rdata"}, reg_rdata, exp_read(a));
        for (int c = 0; c < 2; c++) begin
            logic [AW-1:0] b = AW'(c * 32'h100);
            bit wp  = we && (a == b + 10'h040);
            bit irq = exp_irq(c);
            np[c] = evt[c] ? 1'b1 : (wp ? d[0] : (clr[c] ? 1'b0 : m_pend[c]));
            ne[c] = (we && a == b + 10'h080 && d[0]) ? 1'b1 :
                    ((we && a == b + 10'h0C0 && d[0]) ? 1'b0 : m_en[c]);
            na[c] = (we && a == b + 10'h03C && d[0]) ? 1'b1 : (irq ? 1'b0 : m_arm[c]);
        end
        @(posedge clk);
        for (int c = 0; c < 2; c++) begin
            m_pend[c] = np[c]; m_en[c] = ne[c]; m_arm[c] = na[c];
        end
    endtask

    task automatic rd(input string req, input logic [AW-1:0] a);
        cyc(req, 2'b00, 2'b00, 1'b0, a, 32'd0);
    endtask

    task automatic wr(input string req, input logic [AW-1:0] a, input logic [31:0] d);
        cyc(req, 2'b00, 2'b00, 1'b1, a, d);
    endtask

    // Watchdog
    initial begin
        repeat (MAXC) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [AW-1:0] addrs [12];
        void'($urandom(32'd20240611));
        for (int c = 0; c < 2; c++) begin
            m_pend[c] = 0; m_en[c] = 0; m_arm[c] = 1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state; R2 revision; R3 count
        rd("R1", 10'h040); rd("R1", 10'h140); rd("R1", 10'h080); rd("R1", 10'h1C0);
        rd("R2", 10'h000); rd("R3", 10'h00C);

        // R11: unmapped and read-only offsets
        rd("R11", 10'h004); rd("R11", 10'h044); rd("R11", 10'h240);
        wr("R11", 10'h000, 32'hFFFFFFFF); rd("R2", 10'h000);
        wr("R11", 10'h00C, 32'hFFFFFFFF); rd("R3", 10'h00C);
        wr("R11", 10'h240, 32'hFFFFFFFF); rd("R11", 10'h040); rd("R11", 10'h080);

        // R4 / R5: enable set/clear
        wr("R5", 10'h080, 32'hFFFFFFFE); rd("R5", 10'h080);
        wr("R4", 10'h080, 32'h1); rd("R4", 10'h080); rd("R4", 10'h0C0);
        wr("R5", 10'h0C0, 32'hFFFFFFFE); rd("R5", 10'h0C0);
        wr("R4", 10'h0C0, 32'h1); rd("R4", 10'h080);
        wr("R4", 10'h080, 32'h1);

        // R6 / R8: event gives one pulse
        cyc("R6", 2'b01, 2'b00, 1'b0, 10'h040, 32'd0);
        rd("R8", 10'h040); rd("R8", 10'h040); rd("R9", 10'h03C);

        // R9: disarmed, EOI with bit 0 clear ignored
        wr("R9", 10'h03C, 32'hFFFFFFFE); rd("R9", 10'h040);
        cyc("R9", 2'b01, 2'b00, 1'b0, 10'h040, 32'd0); rd("R9", 10'h040);

        // R10: EOI with pending and enabled re-fires
        wr("R10", 10'h03C, 32'h1); rd("R10", 10'h040); rd("R10", 10'h040);

        // R7: status writes, clear strobe, event beats clear
        wr("R7", 10'h040, 32'h0); rd("R7", 10'h040);
        wr("R7", 10'h040, 32'h1); rd("R7", 10'h040);
        cyc("R7", 2'b00, 2'b01, 1'b0, 10'h040, 32'd0); rd("R7", 10'h040);
        cyc("R7", 2'b01, 2'b01, 1'b0, 10'h040, 32'd0); rd("R7", 10'h040);
        cyc("R7", 2'b01, 2'b00, 1'b1, 10'h040, 32'd0); rd("R7", 10'h040);

        // R12: DED class on its own offsets, SEC untouched
        wr("R12", 10'h180, 32'h1); rd("R12", 10'h080);
        cyc("R12", 2'b10, 2'b00, 1'b0, 10'h140, 32'd0); rd("R12", 10'h140);
        wr("R12", 10'h13C, 32'h1); rd("R12", 10'h040);
        cyc("R12", 2'b00, 2'b10, 1'b0, 10'h140, 32'd0); rd("R12", 10'h040);

        // Random traffic over both classes
        addrs = '{10'h03C, 10'h040, 10'h080, 10'h0C0, 10'h13C, 10'h140,
                  10'h180, 10'h1C0, 10'h000, 10'h00C, 10'h004, 10'h2C0};
        for (int i = 0; i < 4000; i++) begin
            logic [1:0]    ev = {($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0)};
            logic [1:0]    cl = {($urandom_range(0, 11) == 0), ($urandom_range(0, 11) == 0)};
            logic          we = ($urandom_range(0, 2) == 0);
            logic [AW-1:0] a  = addrs[$urandom_range(0, 11)];
            logic [31:0]   d  = $urandom();
            cyc("R6 R7 R8 R9 R10 R12 random", ev, cl, we, a, d);
        end

        done = 1;
        report();
    end

endmodule